// File: doc/BRIEF.md
# Priority-Stacked Interrupt Controller

This block gathers eight interrupt request lines for a processor core and decides which one, if any, may interrupt the code that is running now. Each line has a two-bit priority, a mask bit and a pending bit. The controller keeps a three-bit current execution level. A request is raised to the core only when the best unmasked pending source has a priority strictly above that level.

When the core accepts the request, the controller saves the running level on a four-deep hardware stack. It then raises the running level to the priority of the accepted source and clears that source's pending bit. An end-of-interrupt strobe pops the stack and returns to the level that was saved. A flag shows when the stack is empty. A sticky flag shows that a save pushed the oldest entry out of the stack.

Software programs the masks, the priorities, the pending bits, the level and the eight per-source vector words through a small address/data register bus. While a request is raised, the vector of the winning source is presented beside the source index.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the controller reads as follows: current level 3'b011, empty flag 1, overflow flag 0. Mask, pending, priority, stack and all vector registers read 0, and `irq_req` is 0.
- R2: A rising edge on `irq_in[i]` sets pending bit i at the next clock edge. An input that stays high does not set the bit again. A write to the pending register (address 1, bit i for source i) loads the pending bits whatever the pins are doing.
- R3: `irq_req` is 1 exactly when some unmasked pending source has a priority p (0 lowest, 3 highest) with p > L. Here L is the current level read as a signed 3-bit number, so 3'b111 means -1 and lets every priority through.
- R4: Among the forwarded candidates, the source with the highest priority wins, and the lowest index wins a tie. `irq_src` gives its index and `irq_vec` gives its vector register.
- R5: Setting a mask bit (address 0, bit i) clears pending bit i at the same clock edge. A masked source never wins and never raises `irq_req`.
- R6: `irq_ack` pushes the current level and sets the level to the winner's priority. It also clears the winner's pending bit. This happens only while `irq_req` is 1; otherwise the strobe has no effect.
- R7: `irq_eoi` pops the newest saved level back into the current level. It has no effect when the stack is empty. It is ignored in a cycle where an acknowledge is accepted.
- R8: A push while four levels are already saved discards the oldest entry and sets the overflow flag. The overflow flag stays set until software writes status bit 4 as 1.
- R9: The register map is as follows. Address 2 holds the priority of source i in bits 2i+1:2i. Address 3 is status: bits 2:0 are the level, bit 3 is empty (read-only), bit 4 is overflow. Address 4 is the read-only stack, newest entry in bits 2:0, then 5:3, 8:6 and 11:9. Addresses 8+i hold vector i. Reads are combinational from the address, and unused bits read 0.
- R10: Writing status bits 2:0 sets the current level. An accepted acknowledge or a pop in the same cycle takes precedence over this write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 8 | Interrupt request lines, rising-edge detected |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` |
| irq_req | output | 1 | Interrupt request to the core |
| irq_src | output | 3 | Index of the winning source |
| irq_vec | output | 16 | Vector word of the winning source |
| irq_ack | input | 1 | Core accepts the offered interrupt |
| irq_eoi | input | 1 | Core finished the current handler |

## Verification
On every cycle the assertions check several properties. A mask write leaves no masked bit pending. A raised request always has an unmasked pending source and never appears at level 3. An accepted acknowledge lands the winner's priority in the level and the old level on top of the stack. A pop restores the saved top, and a pop of an empty stack leaves the level alone. A push into a full stack raises the overflow flag. Only the bench's scenarios can show which source wins: the sweep over every pending pattern under several priority layouts and levels checks the tie rule and the signed level compare. The bench scenarios also cover the exact contents of the stack after nested entry, overflow and unwinding, the edge detection of the pins, and the precedence of acknowledge over end-of-interrupt.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Architectural widths of priorities and execution levels.
  localparam int PRIO_W = 2;
  localparam int LVL_W  = PRIO_W + 1;
  localparam logic [LVL_W-1:0] LVL_RESET = 3'b011;

  // Register map (word addresses).
  localparam int A_MASK  = 0;
  localparam int A_PEND  = 1;
  localparam int A_PRIO  = 2;
  localparam int A_STAT  = 3;
  localparam int A_STACK = 4;
  localparam int A_VEC   = 8;

  // Status register field positions.
  localparam int ST_EMPTY = LVL_W;
  localparam int ST_OVF   = LVL_W + 1;

  // A source of priority p may interrupt level c when p > c, with c
  // taken as a signed value so that all-ones stands for "below zero".
  function automatic logic prio_beats_level(input logic [PRIO_W-1:0] p,
                                            input logic [LVL_W-1:0]  c);
    return $signed({1'b0, p}) > $signed(c);
  endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int VEC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        irq_in,
  input  logic                    wr_mask,
  input  logic                    wr_pend,
  input  logic                    wr_prio,
  input  logic [N_SRC-1:0]        wr_vec,
  input  logic [N_SRC-1:0]        wd_bits,
  input  logic [N_SRC*PRIO_W-1:0] wd_prio,
  input  logic [VEC_W-1:0]        wd_vec,
  input  logic [N_SRC-1:0]        ack_clr,
  output logic [N_SRC-1:0]        pend,
  output logic [N_SRC-1:0]        mask,
  output logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic [N_SRC*VEC_W-1:0]  vec_flat
);

  logic [N_SRC-1:0]        irq_q;
  logic [N_SRC-1:0]        rise;
  logic [N_SRC-1:0]        mask_nx;
  logic [N_SRC-1:0]        pend_base;
  logic [N_SRC-1:0]        pend_nx;
  logic [N_SRC*PRIO_W-1:0] prio_q;

  // Pending update: software load or hold-minus-acknowledge, then new
  // pin edges, then the (possibly just written) mask wipes masked bits.
  always_comb begin
    rise      = irq_in & ~irq_q;
    mask_nx   = wr_mask ? wd_bits : mask;
    pend_base = wr_pend ? wd_bits : (pend & ~ack_clr);
    pend_nx   = (pend_base | rise) & ~mask_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend   <= '0;
      mask   <= '0;
      prio_q <= '0;
    end else begin
      irq_q <= irq_in;
      pend  <= pend_nx;
      mask  <= mask_nx;
      if (wr_prio) prio_q <= wd_prio;
    end
  end

  assign prio_flat = prio_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_vec
    logic [VEC_W-1:0] vec_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         vec_q <= '0;
      else if (wr_vec[i]) vec_q <= wd_vec;
    end
    assign vec_flat[i*VEC_W +: VEC_W] = vec_q;
  end

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_prio_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int VEC_W = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC-1:0]        mask,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  input  logic [N_SRC*VEC_W-1:0]  vec_flat,
  input  logic [LVL_W-1:0]        cur_lvl,
  output logic                    req,
  output logic [IDX_W-1:0]        win_idx,
  output logic [PRIO_W-1:0]       win_prio,
  output logic [VEC_W-1:0]        win_vec
);

  // Scan from the top index down with >=, so on equal priority the
  // lower index replaces the earlier pick and wins the tie.
  function automatic logic [IDX_W-1:0] pick_best(
      input logic [N_SRC-1:0]        cand,
      input logic [N_SRC*PRIO_W-1:0] pf);
    logic [IDX_W-1:0]  best;
    logic [PRIO_W-1:0] best_p;
    logic              seen;
    best   = '0;
    best_p = '0;
    seen   = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!seen || pf[i*PRIO_W +: PRIO_W] >= best_p)) begin
        best   = IDX_W'(i);
        best_p = pf[i*PRIO_W +: PRIO_W];
        seen   = 1'b1;
      end
    end
    return best;
  endfunction

  logic [N_SRC-1:0] cand;

  always_comb begin
    cand     = pend & ~mask;
    win_idx  = pick_best(cand, prio_flat);
    win_prio = prio_flat[win_idx*PRIO_W +: PRIO_W];
    win_vec  = vec_flat[win_idx*VEC_W +: VEC_W];
    req      = (|cand) && prio_beats_level(win_prio, cur_lvl);
  end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_prio_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [LVL_W-1:0]       push_lvl,
  input  logic                   pop_req,
  input  logic                   wr_lvl,
  input  logic [LVL_W-1:0]       wd_lvl,
  input  logic                   clr_ovf,
  output logic [LVL_W-1:0]       cur_lvl,
  output logic [DEPTH*LVL_W-1:0] stack_flat,
  output logic                   empty,
  output logic                   full,
  output logic                   ovf,
  output logic                   pop_ev
);

  logic [LVL_W-1:0] spl [DEPTH];
  logic [CNT_W-1:0] cnt;

  assign empty  = (cnt == '0);
  assign full   = (cnt == CNT_W'(DEPTH));
  assign pop_ev = pop_req && !push && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_lvl <= LVL_RESET;
      cnt     <= '0;
      ovf     <= 1'b0;
      for (int i = 0; i < DEPTH; i++) spl[i] <= '0;
    end else begin
      if (clr_ovf) ovf <= 1'b0;
      if (push) begin
        cur_lvl <= push_lvl;
        spl[0]  <= cur_lvl;
        for (int i = 1; i < DEPTH; i++) spl[i] <= spl[i-1];
        if (full) ovf <= 1'b1;
        else      cnt <= cnt + CNT_W'(1);
      end else if (pop_ev) begin
        cur_lvl <= spl[0];
        for (int i = 0; i < DEPTH - 1; i++) spl[i] <= spl[i+1];
        spl[DEPTH-1] <= '0;
        cnt <= cnt - CNT_W'(1);
      end else if (wr_lvl) begin
        cur_lvl <= wd_lvl;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign stack_flat[i*LVL_W +: LVL_W] = spl[i];
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int DEPTH  = 4,
  parameter int VEC_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic [IDX_W-1:0]  irq_src,
  output logic [VEC_W-1:0]  irq_vec,
  input  logic              irq_ack,
  input  logic              irq_eoi
);

  // Decoded bus events.
  logic             wr_mask, wr_pend, wr_prio, wr_stat;
  logic [N_SRC-1:0] wr_vec;

  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(A_MASK));
  assign wr_pend = bus_wr && (bus_addr == ADDR_W'(A_PEND));
  assign wr_prio = bus_wr && (bus_addr == ADDR_W'(A_PRIO));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(A_STAT));

  for (genvar i = 0; i < N_SRC; i++) begin : g_vdec
    assign wr_vec[i] = bus_wr && (bus_addr == ADDR_W'(A_VEC + i));
  end

  // Internal state and events, named for the checker.
  logic [N_SRC-1:0]        pend, mask, ack_clr;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic [N_SRC*VEC_W-1:0]  vec_flat;
  logic [PRIO_W-1:0]       win_prio;
  logic [LVL_W-1:0]        cur_lvl;
  logic [DEPTH*LVL_W-1:0]  stack_flat;
  logic [LVL_W-1:0]        stack_top;
  logic                    empty, full, ovf, pop_ev, ack_ev;

  assign ack_ev    = irq_ack && irq_req;
  assign ack_clr   = ack_ev ? (N_SRC'(1) << irq_src) : '0;
  assign stack_top = stack_flat[LVL_W-1:0];

  irq_src_bank #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .wr_mask   (wr_mask),
    .wr_pend   (wr_pend),
    .wr_prio   (wr_prio),
    .wr_vec    (wr_vec),
    .wd_bits   (bus_wdata[N_SRC-1:0]),
    .wd_prio   (bus_wdata[N_SRC*PRIO_W-1:0]),
    .wd_vec    (bus_wdata[VEC_W-1:0]),
    .ack_clr   (ack_clr),
    .pend      (pend),
    .mask      (mask),
    .prio_flat (prio_flat),
    .vec_flat  (vec_flat)
  );

  irq_select #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_sel (
    .pend      (pend),
    .mask      (mask),
    .prio_flat (prio_flat),
    .vec_flat  (vec_flat),
    .cur_lvl   (cur_lvl),
    .req       (irq_req),
    .win_idx   (irq_src),
    .win_prio  (win_prio),
    .win_vec   (irq_vec)
  );

  irq_level_stack #(.DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (ack_ev),
    .push_lvl   ({1'b0, win_prio}),
    .pop_req    (irq_eoi),
    .wr_lvl     (wr_stat),
    .wd_lvl     (bus_wdata[LVL_W-1:0]),
    .clr_ovf    (wr_stat && bus_wdata[ST_OVF]),
    .cur_lvl    (cur_lvl),
    .stack_flat (stack_flat),
    .empty      (empty),
    .full       (full),
    .ovf        (ovf),
    .pop_ev     (pop_ev)
  );

  // Combinational read mux.
  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      A_MASK:  bus_rdata = DATA_W'(mask);
      A_PEND:  bus_rdata = DATA_W'(pend);
      A_PRIO:  bus_rdata = DATA_W'(prio_flat);
      A_STAT:  bus_rdata = DATA_W'({ovf, empty, cur_lvl});
      A_STACK: bus_rdata = DATA_W'(stack_flat);
      default: bus_rdata = '0;
    endcase
    for (int i = 0; i < N_SRC; i++) begin
      if (bus_addr == ADDR_W'(A_VEC + i))
        bus_rdata = DATA_W'(vec_flat[i*VEC_W +: VEC_W]);
    end
  end

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_ack,
  input logic              irq_eoi,
  input logic              irq_req,
  input logic [N_SRC-1:0]  pend,
  input logic [N_SRC-1:0]  mask,
  input logic [PRIO_W-1:0] win_prio,
  input logic [LVL_W-1:0]  cur_lvl,
  input logic [LVL_W-1:0]  stack_top,
  input logic              empty,
  input logic              full,
  input logic              ovf
);

  a_r5_mask_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(A_MASK)) |=> ((pend & mask) == '0));

  a_r3_req_needs_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((pend & ~mask) != '0));

  a_r10_top_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == 3'b011) |-> !irq_req);

  a_r6_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=>
      (cur_lvl == {1'b0, $past(win_prio)}) && (stack_top == $past(cur_lvl)) && !empty);

  a_r7_eoi_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_eoi && !(irq_ack && irq_req) && !empty) |=> (cur_lvl == $past(stack_top)));

  a_r7_eoi_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_eoi && !irq_ack && empty && !bus_wr) |=> $stable(cur_lvl));

  a_r8_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && full) |=> (ovf && full));

endmodule

bind irq_prio_ctrl irq_prio_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .irq_ack   (irq_ack),
  .irq_eoi   (irq_eoi),
  .irq_req   (irq_req),
  .pend      (pend),
  .mask      (mask),
  .win_prio  (win_prio),
  .cur_lvl   (cur_lvl),
  .stack_top (stack_top),
  .empty     (empty),
  .full      (full),
  .ovf       (ovf)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_in = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq_req;
  logic [2:0]  irq_src;
  logic [15:0] irq_vec;
  logic        irq_ack = 1'b0;
  logic        irq_eoi = 1'b0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_src(irq_src), .irq_vec(irq_vec),
    .irq_ack(irq_ack), .irq_eoi(irq_eoi)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 4'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic rd_chk(input string tag, input int a, input int exp);
    int d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic strobe(input bit ack, input bit eoi);
    @(negedge clk);
    irq_ack = ack; irq_eoi = eoi;
    @(negedge clk);
    irq_ack = 1'b0; irq_eoi = 1'b0;
  endtask

  function automatic int vec_of(input int i);
    return 16'h1000 + i * 16'h0111;
  endfunction

  // Reference arbitration: walk levels from highest, first index found.
  task automatic model(input int pend, input int mask, input int prio,
                       input int cur, output bit req, output int src);
    int lvl_s;
    int found;
    found = -1;
    lvl_s = -2;
    for (int lv = 3; lv >= 0 && found < 0; lv--)
      for (int i = 0; i < 8 && found < 0; i++)
        if (pend[i] && !mask[i] && ((prio >> (2*i)) & 3) == lv) begin
          found = i; lvl_s = lv;
        end
    req = (found >= 0) && (lvl_s > ((cur >= 4) ? cur - 8 : cur));
    src = found;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit exp_req;
    int exp_src;
    int prio_cfg [3];
    int cur_cfg [5];
    prio_cfg = '{16'hAAAA, 16'hE4E4, 16'h1B1B};
    cur_cfg  = '{7, 0, 1, 2, 3};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state.
    rd_chk("R1 status", 3, 16'h000B);
    rd_chk("R1 mask", 0, 0);
    rd_chk("R1 pending", 1, 0);
    rd_chk("R1 priority", 2, 0);
    rd_chk("R1 stack", 4, 0);
    rd_chk("R1 vector0", 8, 0);
    check("R1 irq_req", int'(irq_req), 0);

    // R9 vector registers.
    for (int i = 0; i < 8; i++) wr(8 + i, vec_of(i));
    for (int i = 0; i < 8; i++) rd_chk("R9 vector readback", 8 + i, vec_of(i));

    // R3/R4 sweep over pending patterns, priority layouts and levels.
    for (int c = 0; c < 3; c++) begin
      wr(2, prio_cfg[c]);
      rd_chk("R9 priority readback", 2, prio_cfg[c]);
      for (int l = 0; l < 5; l++) begin
        wr(3, cur_cfg[l]);
        for (int p = 0; p < 256; p++) begin
          wr(1, p);
          #1;
          model(p, 0, prio_cfg[c], cur_cfg[l], exp_req, exp_src);
          check("R3 irq_req", int'(irq_req), int'(exp_req));
          if (exp_req) begin
            check("R4 irq_src", int'(irq_src), exp_src);
            check("R4 irq_vec", int'(irq_vec), vec_of(exp_src));
          end
        end
      end
    end

    // R5 masking sweep.
    wr(2, 16'hE4E4);
    wr(3, 7);
    wr(0, 16'h5A);
    for (int p = 0; p < 256; p++) begin
      wr(1, p);
      rd_chk("R5 pending masked", 1, p & ~8'h5A);
      model(p, 8'h5A, 16'hE4E4, 7, exp_req, exp_src);
      check("R5 irq_req", int'(irq_req), int'(exp_req));
      if (exp_req) check("R5 irq_src", int'(irq_src), exp_src);
    end
    wr(0, 0);
    wr(1, 16'hFF);
    wr(0, 16'h0F);
    rd_chk("R5 mask write clears pending", 1, 16'hF0);
    wr(0, 0);
    wr(1, 0);

    // R2 pin edge detection.
    @(negedge clk); irq_in = 8'h20;
    @(negedge clk);
    rd_chk("R2 rising edge sets pending", 1, 16'h20);
    strobe(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    rd_chk("R2 held pin does not re-set", 1, 0);
    irq_in = 8'h00;
    @(negedge clk); irq_in = 8'h20;
    @(negedge clk);
    rd_chk("R2 second edge sets pending", 1, 16'h20);
    irq_in = 8'h00;
    strobe(1'b0, 1'b1);
    strobe(1'b1, 1'b0);
    wr(3, 7);
    wr(1, 0);
    wr(1, 16'h80);
    rd_chk("R2 software set with pin low", 1, 16'h80);
    wr(1, 0);
    // Unwind whatever the edge test pushed, then reset level.
    for (int k = 0; k < 5; k++) strobe(1'b0, 1'b1);
    wr(3, 16'h17);
    rd_chk("R8 overflow cleared by write", 3, 16'h000F);

    // R6 nested entry with priorities in0=0 in1=1 in2=2 in3=3.
    wr(2, 16'hE4E4);
    wr(1, 16'h01); strobe(1'b1, 1'b0);
    rd_chk("R6 level after ack 0", 3, 16'h0000);
    rd_chk("R6 stack after ack 0", 4, 16'h0007);
    rd_chk("R6 pending cleared", 1, 0);
    wr(1, 16'h02); strobe(1'b1, 1'b0);
    rd_chk("R6 stack after ack 1", 4, 16'h0038);
    wr(1, 16'h04); strobe(1'b1, 1'b0);
    rd_chk("R6 stack after ack 2", 4, 16'h01C1);
    wr(1, 16'h08); strobe(1'b1, 1'b0);
    rd_chk("R6 stack after ack 3", 4, 16'h0E0A);
    rd_chk("R6 level 3", 3, 16'h0003);
    // R8 fifth push drops oldest.
    wr(3, 7);
    wr(1, 16'h01); strobe(1'b1, 1'b0);
    rd_chk("R8 stack after overflow", 4, 16'h0057);
    rd_chk("R8 overflow flag", 3, 16'h0010);
    strobe(1'b1, 1'b0);
    rd_chk("R6 ack without request ignored", 4, 16'h0057);
    rd_chk("R6 ack without request level", 3, 16'h0010);
    // R7 unwinding.
    strobe(1'b0, 1'b1);
    rd_chk("R7 pop 1 level", 3, 16'h0017);
    rd_chk("R7 pop 1 stack", 4, 16'h000A);
    strobe(1'b0, 1'b1);
    rd_chk("R7 pop 2 level", 3, 16'h0012);
    strobe(1'b0, 1'b1);
    rd_chk("R7 pop 3 level", 3, 16'h0011);
    strobe(1'b0, 1'b1);
    rd_chk("R7 pop 4 level", 3, 16'h0018);
    strobe(1'b0, 1'b1);
    rd_chk("R7 pop on empty ignored", 3, 16'h0018);
    wr(3, 16'h17);
    rd_chk("R8 clear keeps level write", 3, 16'h000F);

    // R7 acknowledge wins over end-of-interrupt.
    wr(1, 16'h08);
    strobe(1'b1, 1'b1);
    rd_chk("R7 ack precedence level", 3, 16'h0003);
    rd_chk("R7 ack precedence stack", 4, 16'h0007);
    strobe(1'b0, 1'b1);
    rd_chk("R7 return to saved level", 3, 16'h000F);

    // R10 level write gates forwarding.
    wr(1, 16'h08);
    wr(3, 3);
    #1 check("R10 level 3 blocks", int'(irq_req), 0);
    wr(3, 2);
    #1 check("R10 level 2 passes", int'(irq_req), 1);
    check("R10 source", int'(irq_src), 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule